// File: doc/BRIEF.md
# Quadrature Encoder Decoder with Position Counter

This block turns the two phase signals of an incremental encoder into counted position. Each phase input is first brought into the clock domain by a two-flop synchronizer and then passed through a small digital filter that only accepts a new level once it has persisted for three consecutive clocks. The filtered pair is compared with its previous value. Transitions that advance along the Gray sequence count up, transitions that retreat count down, and a jump of both phases at once is discarded.

A two-bit mode input chooses how many of the four transitions per encoder cycle produce a count: all four, only the two on phase A, or just one. A fourth code switches counting off. Every counted transition raises a one-clock pulse. A direction level is registered one clock ahead of that pulse, and a 32-bit up/down counter moves by one at the same edge that raises the pulse. An active-low reset clears the whole block asynchronously.

Top module: `qdec_counter`

## Requirements
- R1: With mode 2'b00 (4x), every valid transition of the filtered pair {A,B} counts. The up sequence is 00→10→11→01→00 (A leads B), and the reverse sequence counts down.
- R2: With mode 2'b01 (2x), only transitions in which A changes count (00↔10 and 11↔01). Transitions of B alone produce no count.
- R3: With mode 2'b10 (1x), only A rising while B is low (00→10, up) and A falling while B is low (10→00, down) count.
- R4: With mode 2'b11, no transition produces a count and the position holds.
- R5: A filtered change of both phases in the same clock is invalid and produces no count. Decoding then continues from the new state.
- R6: A phase level must persist for three clocks after the two-flop synchronizer before it is accepted. A pulse of two clocks has no effect, and a pulse of three clocks is accepted.
- R7: cnt_pulse is high for one clock per isolated counted transition. cnt_up (1 = up, 0 = down) takes its value at least one clock before the pulse rises and holds it during the pulse.
- R8: position is a 32-bit counter that changes by +1 or −1 in the cycle the pulse is high, holds otherwise, and wraps modulo 2^32 (0 − 1 = 32'hFFFF_FFFF).
- R9: rst_n low clears position, cnt_up and cnt_pulse at once without waiting for a clock, and discards any count still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| mode | input | 2 | 00 = 4x, 01 = 2x, 10 = 1x, 11 = counting off |
| cnt_pulse | output | 1 | One-clock pulse per counted transition |
| cnt_up | output | 1 | Direction of the last count, 1 = up |
| position | output | 32 | Position counter |

## Verification
The two functions that can fall in the same cycle are a count still travelling through the pulse pipeline and the asynchronous reset. The bench moves phase A and then pulls reset low six clocks later, in the window after the decoder has registered the step but before the pulse would rise. It judges the outcome by checking that position and direction read zero straight away, that no pulse ever appears, and that the scoreboard queue stays empty once the phases are back at rest and reset is released.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    MODE_X4  = 2'b00,
    MODE_X2  = 2'b01,
    MODE_X1  = 2'b10,
    MODE_OFF = 2'b11
  } qd_mode_e;

  typedef struct packed {
    logic valid;
    logic up;
  } qd_step_t;

  // Gray successor of {A,B} when A leads B
  function automatic logic [1:0] qd_next_up(input logic [1:0] s);
    return {~s[0], s[1]};
  endfunction

  // Gray successor of {A,B} when B leads A
  function automatic logic [1:0] qd_next_dn(input logic [1:0] s);
    return {s[0], ~s[1]};
  endfunction

  // Decide whether prev->curr is a counted step in mode m
  function automatic qd_step_t qd_classify(input logic [1:0] prev,
                                           input logic [1:0] curr,
                                           input qd_mode_e m);
    qd_step_t r;
    logic is_up, is_dn, a_moved, b_low;
    is_up   = (curr == qd_next_up(prev));
    is_dn   = (curr == qd_next_dn(prev));
    a_moved = prev[1] ^ curr[1];
    b_low   = ~prev[0] & ~curr[0];
    r.up    = is_up;
    unique case (m)
      MODE_X4:  r.valid = is_up | is_dn;
      MODE_X2:  r.valid = (is_up | is_dn) & a_moved;
      MODE_X1:  r.valid = (is_up | is_dn) & a_moved & b_low;
      default:  r.valid = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] qd_step_count(input logic [31:0] cnt,
                                                input logic up);
    return up ? cnt + 32'd1 : cnt - 32'd1;
  endfunction

endpackage

// File: rtl/qdec_phase_filter.sv
module qdec_phase_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int HIST_W = FILT_LEN - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HIST_W-1:0]      hist_q;
  logic [FILT_LEN-1:0]    window;

  assign window = {hist_q, sync_q[SYNC_STAGES-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
      filt   <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      hist_q <= window[HIST_W-1:0];
      if (&window)
        filt <= 1'b1;
      else if (~|window)
        filt <= 1'b0;
    end
  end
endmodule

// File: rtl/qdec_step_decode.sv
module qdec_step_decode
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ab,
  input  logic [1:0] mode,
  output logic       step_evt,
  output logic       step_up
);
  logic [1:0] prev_q;
  qd_step_t   step;

  always_comb step = qd_classify(prev_q, ab, qd_mode_e'(mode));

  assign step_evt = step.valid;
  assign step_up  = step.up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= ab;
  end
endmodule

// File: rtl/qdec_position.sv
module qdec_position
  import qdec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_evt,
  input  logic             step_up,
  output logic             cnt_pulse,
  output logic             cnt_up,
  output logic [CNT_W-1:0] position
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      cnt_up    <= 1'b0;
      cnt_pulse <= 1'b0;
      position  <= '0;
    end else begin
      pend_q    <= step_evt;
      cnt_pulse <= pend_q;
      if (step_evt) cnt_up <= step_up;
      if (pend_q)
        position <= CNT_W'(qd_step_count(32'(position), cnt_up));
    end
  end
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic [1:0]       mode,
  output logic             cnt_pulse,
  output logic             cnt_up,
  output logic [CNT_W-1:0] position
);
  localparam int NPH = 2;

  logic [NPH-1:0] raw_ab;
  logic [NPH-1:0] filt_ab;
  logic           step_evt;
  logic           step_up;

  assign raw_ab = {phase_a, phase_b};

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    qdec_phase_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_ab[g]),
      .filt (filt_ab[g])
    );
  end

  qdec_step_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .ab      (filt_ab),
    .mode    (mode),
    .step_evt(step_evt),
    .step_up (step_up)
  );

  qdec_position #(.CNT_W(CNT_W)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_evt (step_evt),
    .step_up  (step_up),
    .cnt_pulse(cnt_pulse),
    .cnt_up   (cnt_up),
    .position (position)
  );
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic [1:0]       filt,
  input logic             step_evt,
  input logic             cnt_pulse,
  input logic             cnt_up,
  input logic [CNT_W-1:0] position
);
  AST_MODE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> !step_evt); // R4

  AST_DOUBLE_FLIP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt ^ $past(filt)) == 2'b11) |-> !step_evt); // R5

  AST_PULSE_FROM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |-> $past(step_evt, 2)); // R7

  AST_DIR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |-> $stable(cnt_up)); // R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |-> (position == (cnt_up ? $past(position) + CNT_W'(1)
                                       : $past(position) - CNT_W'(1)))); // R8

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_pulse |-> $stable(position)); // R8
endmodule

bind qdec_counter qdec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .filt     (filt_ab),
  .step_evt (step_evt),
  .cnt_pulse(cnt_pulse),
  .cnt_up   (cnt_up),
  .position (position)
);

// File: tb/tb_qdec_counter.sv
module tb_qdec_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_a = 1'b0;
  logic        phase_b = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        cnt_pulse;
  logic        cnt_up;
  logic [31:0] position;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    bit          up;
    logic [31:0] cnt;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [1:0]  st = 2'b00;
  logic [31:0] exp_cnt = '0;

  always #10 clk = ~clk;

  qdec_counter dut (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .mode(mode), .cnt_pulse(cnt_pulse), .cnt_up(cnt_up), .position(position)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Position of a state along the up cycle 00,10,11,01
  function automatic int gpos(input logic [1:0] s);
    case (s)
      2'b00:   return 0;
      2'b10:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  // Bench model: push an expected count for st -> nxt, if it counts
  task automatic model(input logic [1:0] nxt, input string req);
    int  d;
    bit  cnt_it;
    d = (gpos(nxt) - gpos(st) + 4) % 4;
    cnt_it = (d == 1) || (d == 3);
    case (mode)
      2'b01: cnt_it = cnt_it && (st[1] != nxt[1]);
      2'b10: cnt_it = cnt_it && (gpos(st) < 2) && (gpos(nxt) < 2);
      2'b11: cnt_it = 1'b0;
      default: ;
    endcase
    if (cnt_it) begin
      exp_cnt = (d == 1) ? exp_cnt + 1 : exp_cnt - 1;
      sb.push_back('{up: (d == 1), cnt: exp_cnt, req: req});
    end
    st = nxt;
  endtask

  task automatic move(input logic a, input logic b, input string req);
    @(negedge clk);
    phase_a = a;
    phase_b = b;
    model({a, b}, req);
    repeat (12) @(negedge clk);
  endtask

  task automatic drained(input string req);
    chk(sb.size() == 0, req, "expected counts left pending", 32'(sb.size()), 0);
    chk(position == exp_cnt, req, "position", position, exp_cnt);
  endtask

  // Monitor: pops one expected item per observed pulse
  bit prev_up    = 1'b0;
  bit prev_pulse = 1'b0;
  always @(negedge clk) begin
    if (rst_n && cnt_pulse) begin
      chk(!prev_pulse, "R7", "pulse longer than one clock", 1, 0);
      chk(prev_up == cnt_up, "R7", "direction not set up before pulse",
          32'(prev_up), 32'(cnt_up));
      if (sb.size() == 0) begin
        chk(1'b0, "R5", "unexpected count pulse", position, exp_cnt);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cnt_up == e.up, e.req, "direction", 32'(cnt_up), 32'(e.up));
        chk(position == e.cnt, e.req, "position at pulse", position, e.cnt);
      end
    end
    prev_up    = cnt_up;
    prev_pulse = rst_n && cnt_pulse;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(position == 0, "R9", "reset position", position, 0);
    chk(cnt_pulse == 0, "R9", "reset pulse", 32'(cnt_pulse), 0);
    chk(cnt_up == 0, "R9", "reset direction", 32'(cnt_up), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: 4x, two full cycles up, then three steps down
    mode = 2'b00;
    for (int k = 0; k < 2; k++) begin
      move(1, 0, "R1"); move(1, 1, "R1"); move(0, 1, "R1"); move(0, 0, "R1");
    end
    move(0, 1, "R1"); move(1, 1, "R1"); move(1, 0, "R1");
    drained("R1");

    // R8: walk down through zero and back up
    move(0, 0, "R8"); move(0, 1, "R8"); move(1, 1, "R8"); move(1, 0, "R8");
    move(0, 0, "R8"); move(0, 1, "R8");
    drained("R8");
    chk(position == 32'hFFFF_FFFF, "R8", "wrap below zero", position, 32'hFFFF_FFFF);
    move(0, 0, "R8");
    chk(position == 32'h0, "R8", "wrap back to zero", position, 0);

    // R2: 2x, one cycle up, one cycle down
    mode = 2'b01;
    move(1, 0, "R2"); move(1, 1, "R2"); move(0, 1, "R2"); move(0, 0, "R2");
    move(0, 1, "R2"); move(1, 1, "R2"); move(1, 0, "R2"); move(0, 0, "R2");
    move(0, 1, "R2");
    drained("R2");
    move(0, 0, "R2");

    // R3: 1x, two cycles up, one cycle down
    mode = 2'b10;
    for (int k = 0; k < 2; k++) begin
      move(1, 0, "R3"); move(1, 1, "R3"); move(0, 1, "R3"); move(0, 0, "R3");
    end
    move(0, 1, "R3"); move(1, 1, "R3"); move(1, 0, "R3"); move(0, 0, "R3");
    drained("R3");

    // R4: counting off
    mode = 2'b11;
    move(1, 0, "R4"); move(1, 1, "R4"); move(0, 1, "R4"); move(0, 0, "R4");
    drained("R4");

    // R5: both phases flip together
    mode = 2'b00;
    move(1, 1, "R5");
    drained("R5");
    move(0, 1, "R5");
    move(1, 0, "R5");
    drained("R5");
    move(0, 0, "R5");

    // R6: two-clock glitch rejected, three-clock pulse accepted
    @(negedge clk); phase_a = 1'b1;
    repeat (2) @(negedge clk); phase_a = 1'b0;
    repeat (12) @(negedge clk);
    drained("R6");
    @(negedge clk); phase_a = 1'b1; model(2'b10, "R6");
    repeat (3) @(negedge clk); phase_a = 1'b0; model(2'b00, "R6");
    repeat (14) @(negedge clk);
    drained("R6");

    // R9: reset collides with a count in flight
    move(1, 0, "R9");
    chk(position != 0, "R9", "nonzero before reset", position, exp_cnt);
    @(negedge clk); phase_a = 1'b0;
    repeat (6) @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    chk(position == 0, "R9", "async clear of position", position, 0);
    chk(cnt_up == 0, "R9", "async clear of direction", 32'(cnt_up), 0);
    repeat (3) @(negedge clk);
    rst_n   = 1'b1;
    st      = 2'b00;
    exp_cnt = '0;
    repeat (14) @(negedge clk);
    drained("R9");
    move(1, 0, "R9");
    drained("R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule